// File: doc/BRIEF.md
# Hold and Low-Power Mode Controller

This block sequences the power states of a small controller core. The decoded instruction logic sends it clock-stop and wait requests. Configuration inputs choose how each request is taken and released, and an external HOLD pin gives the wake-up event. The block drives an oscillator enable and a CPU clock enable. It also registers the display, CMOS and open-drain pin values that reach the pads, forcing or freezing them according to the current state.

After reset is released, the block enables the CPU for one cycle with a start-at-address-zero indication. Clock-stop mode turns off both the oscillator and the CPU clock and parks every output pin. Wake-up starts a fixed oscillator-settling interval before the CPU clock returns. Wait mode has two variants. In one, only the oscillator keeps running and the display is blanked. In the other, only the CPU is paused and every pin is retained. Wait mode leaves only when HOLD changes.

The controller runs on an always-on clock. HOLD is synchronised with two flops, and every decision about HOLD uses the synchronised copy.

Top module: `hold_pwr_ctrl`

## Requirements
- R1: While `rst` is high, `status` is 0 (reset), `cpu_clk_en` is 0, `osc_en` is 1 and all pin outputs are 0. On the first rising edge with `rst` low, `status` becomes 1 (run) and `vec_zero` is high for exactly that one cycle.
- R2: HOLD is seen only through a two-flop synchroniser. A change on `hold_in` can alter `status` no earlier than the third rising edge after the change.
- R3: In run, a `req_ckstp` with `cks_force`=0 enters clock stop (`status`=2) only when synchronised HOLD is low. Otherwise the request is dropped.
- R4: In run, a `req_ckstp` with `cks_force`=1 enters clock stop whatever the HOLD level.
- R5: In clock stop, `osc_en` and `cpu_clk_en` are 0. From the next cycle on, `disp_out` and `cmos_out` are 0 and `od_out` is 0, where a 1 on an `od_out` bit turns that open-drain transistor on and a 0 releases it.
- R6: With `cks_wake_edge`=0, clock stop is left when synchronised HOLD is high. With `cks_wake_edge`=1, it is left when synchronised HOLD differs from the value it had on entry.
- R7: After a clock-stop wake, `status` is 3 (settling) with `osc_en`=1 and `cpu_clk_en`=0 for exactly SETTLE_CYC cycles (default 16), then 1.
- R8: In run, `req_wait` enters wait whatever the HOLD level. A clock-stop request that takes effect wins over a simultaneous wait request. A blocked conditional clock-stop request does not prevent the wait.
- R9: Wait with `wait_cpu_only`=0 gives `status`=4: `osc_en`=1, `cpu_clk_en`=0, `disp_out` forced to 0 from the next cycle, and `cmos_out` and `od_out` frozen.
- R10: Wait with `wait_cpu_only`=1 gives `status`=5: `osc_en`=1, `cpu_clk_en`=0, and all three pin outputs frozen.
- R11: Wait is left for run only when synchronised HOLD differs from its value on entry. The HOLD level present at entry never wakes it.
- R12: `req_ckstp` and `req_wait` have no effect in any state other than run.
- R13: In run, each pin output equals its pin input from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_in | input | 1 | Asynchronous HOLD pin |
| req_ckstp | input | 1 | Clock-stop request pulse from the decoder |
| req_wait | input | 1 | Wait request pulse from the decoder |
| cks_force | input | 1 | 1: clock stop ignores HOLD on entry |
| cks_wake_edge | input | 1 | 1: clock stop wakes on HOLD change; 0: on HOLD high |
| wait_cpu_only | input | 1 | 1: wait pauses only the CPU; 0: only the oscillator runs |
| disp_in | input | DISP_W | Display values from the core |
| cmos_in | input | CMOS_W | CMOS port values from the core |
| od_in | input | OD_W | Open-drain values from the core (1 = on) |
| disp_out | output | DISP_W | Display pins |
| cmos_out | output | CMOS_W | CMOS port pins |
| od_out | output | OD_W | Open-drain pins (1 = on, 0 = off) |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| vec_zero | output | 1 | One-cycle start-from-address-zero pulse |
| status | output | 3 | 0 reset, 1 run, 2 clock stop, 3 settling, 4 wait oscillator-only, 5 wait CPU-paused |

## Verification
On every cycle, the assertions check the pin treatment in each state: blanking in clock stop, display blanking with the other pins frozen in oscillator-only wait, full freezing in CPU-paused wait, and one-cycle following in run. They also check that wait only returns to run, that wait does not move without a HOLD change, that a conditional clock stop is held off by a high HOLD, that level-mode clock stop stays put while HOLD is low, and that the settle counter stays within bounds. Other behaviour shows up only in the directed scenarios. These are the exact settle length, the three-edge HOLD latency, the fact that an edge-mode wake ignores the entry level, the priority between simultaneous requests, and the single-cycle address-zero pulse after reset.

// File: rtl/hold_pwr_pkg.sv
package hold_pwr_pkg;
  typedef enum logic [2:0] {
    ST_RST    = 3'd0,
    ST_RUN    = 3'd1,
    ST_CKS    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_WOSC   = 3'd4,
    ST_WCPU   = 3'd5
  } pstate_t;
endpackage

// File: rtl/hold_sync.sv
module hold_sync (
  input  logic clk,
  input  logic rst,
  input  logic hold_in,
  input  logic capture,
  output logic hold_s,
  output logic chg
);
  logic s1_q, s2_q, ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      s1_q <= hold_in;
      s2_q <= s1_q;
      if (capture) ref_q <= s2_q;
    end
  end

  assign hold_s = s2_q;
  assign chg    = s2_q ^ ref_q;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = en && (cnt_q == LAST);

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q <= LAST)); // R7
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_ckstp,
  input  logic    req_wait,
  input  logic    cks_force,
  input  logic    cks_wake_edge,
  input  logic    wait_cpu_only,
  input  logic    hold_s,
  input  logic    chg,
  input  logic    settle_done,
  output pstate_t state,
  output logic    capture,
  output logic    settle_en,
  output logic    vec_zero
);
  pstate_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RST: nxt = ST_RUN;
      ST_RUN: begin
        if (req_ckstp && (cks_force || !hold_s)) nxt = ST_CKS;
        else if (req_wait) nxt = wait_cpu_only ? ST_WCPU : ST_WOSC;
      end
      ST_CKS:    if (cks_wake_edge ? chg : hold_s) nxt = ST_SETTLE;
      ST_SETTLE: if (settle_done) nxt = ST_RUN;
      ST_WOSC,
      ST_WCPU:   if (chg) nxt = ST_RUN;
      default:   nxt = ST_RST;
    endcase
  end

  assign capture   = (state == ST_RUN) && (nxt != ST_RUN);
  assign settle_en = (state == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RST;
      vec_zero <= 1'b0;
    end else begin
      state    <= nxt;
      vec_zero <= (state == ST_RST);
    end
  end

  AST_VEC_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    vec_zero |-> (state == ST_RUN)); // R1
  AST_COND_CKS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && req_ckstp && !cks_force && hold_s && !req_wait) |=> (state == ST_RUN)); // R3
  AST_CKS_LEVEL_STAY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CKS && !cks_wake_edge && !hold_s) |=> (state == ST_CKS)); // R6
  AST_WOSC_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WOSC && !chg) |=> (state == ST_WOSC)); // R11
  AST_WCPU_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WCPU && !chg) |=> (state == ST_WCPU)); // R11
  AST_WAIT_EXIT_RUN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WOSC || state == ST_WCPU) |=> (state == $past(state) || state == ST_RUN)); // R12
endmodule

// File: rtl/pin_force.sv
module pin_force
  import hold_pwr_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int CMOS_W = 4,
  parameter int OD_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pstate_t           state,
  input  logic [DISP_W-1:0] disp_in,
  input  logic [CMOS_W-1:0] cmos_in,
  input  logic [OD_W-1:0]   od_in,
  output logic [DISP_W-1:0] disp_out,
  output logic [CMOS_W-1:0] cmos_out,
  output logic [OD_W-1:0]   od_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_out <= '0;
      cmos_out <= '0;
      od_out   <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          disp_out <= disp_in;
          cmos_out <= cmos_in;
          od_out   <= od_in;
        end
        ST_WOSC: disp_out <= '0;
        ST_WCPU: ;
        default: begin
          disp_out <= '0;
          cmos_out <= '0;
          od_out   <= '0;
        end
      endcase
    end
  end

  AST_CKS_PINS_PARKED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CKS) |=> (disp_out == '0 && cmos_out == '0 && od_out == '0)); // R5
  AST_WOSC_PINS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WOSC) |=> (disp_out == '0 && $stable(cmos_out) && $stable(od_out))); // R9
  AST_WCPU_PINS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WCPU) |=> ($stable(disp_out) && $stable(cmos_out) && $stable(od_out))); // R10
  AST_RUN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |=> (disp_out == $past(disp_in) && cmos_out == $past(cmos_in) && od_out == $past(od_in))); // R13
endmodule

// File: rtl/hold_pwr_ctrl.sv
module hold_pwr_ctrl
  import hold_pwr_pkg::*;
#(
  parameter int DISP_W     = 8,
  parameter int CMOS_W     = 4,
  parameter int OD_W       = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_in,
  input  logic              req_ckstp,
  input  logic              req_wait,
  input  logic              cks_force,
  input  logic              cks_wake_edge,
  input  logic              wait_cpu_only,
  input  logic [DISP_W-1:0] disp_in,
  input  logic [CMOS_W-1:0] cmos_in,
  input  logic [OD_W-1:0]   od_in,
  output logic [DISP_W-1:0] disp_out,
  output logic [CMOS_W-1:0] cmos_out,
  output logic [OD_W-1:0]   od_out,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              vec_zero,
  output logic [2:0]        status
);
  pstate_t state;
  logic    hold_s, chg, capture, settle_en, settle_done;

  hold_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .hold_in (hold_in),
    .capture (capture),
    .hold_s  (hold_s),
    .chg     (chg)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .en   (settle_en),
    .done (settle_done)
  );

  hold_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_ckstp     (req_ckstp),
    .req_wait      (req_wait),
    .cks_force     (cks_force),
    .cks_wake_edge (cks_wake_edge),
    .wait_cpu_only (wait_cpu_only),
    .hold_s        (hold_s),
    .chg           (chg),
    .settle_done   (settle_done),
    .state         (state),
    .capture       (capture),
    .settle_en     (settle_en),
    .vec_zero      (vec_zero)
  );

  pin_force #(.DISP_W(DISP_W), .CMOS_W(CMOS_W), .OD_W(OD_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .disp_in  (disp_in),
    .cmos_in  (cmos_in),
    .od_in    (od_in),
    .disp_out (disp_out),
    .cmos_out (cmos_out),
    .od_out   (od_out)
  );

  assign osc_en     = (state != ST_CKS);
  assign cpu_clk_en = (state == ST_RUN);
  assign status     = state;
endmodule

// File: tb/tb_hold_pwr_ctrl.sv
module tb_hold_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DISP_W = 8, CMOS_W = 4, OD_W = 4, SETTLE_CYC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_in = 1'b0, req_ckstp = 1'b0, req_wait = 1'b0;
  logic cks_force = 1'b0, cks_wake_edge = 1'b0, wait_cpu_only = 1'b0;
  logic [DISP_W-1:0] disp_in = 8'hA5;
  logic [CMOS_W-1:0] cmos_in = 4'h9;
  logic [OD_W-1:0]   od_in   = 4'h6;
  logic [DISP_W-1:0] disp_out;
  logic [CMOS_W-1:0] cmos_out;
  logic [OD_W-1:0]   od_out;
  logic osc_en, cpu_clk_en, vec_zero;
  logic [2:0] status;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_pwr_ctrl #(.DISP_W(DISP_W), .CMOS_W(CMOS_W), .OD_W(OD_W), .SETTLE_CYC(SETTLE_CYC)) dut (
    .clk(clk), .rst(rst), .hold_in(hold_in), .req_ckstp(req_ckstp), .req_wait(req_wait),
    .cks_force(cks_force), .cks_wake_edge(cks_wake_edge), .wait_cpu_only(wait_cpu_only),
    .disp_in(disp_in), .cmos_in(cmos_in), .od_in(od_in),
    .disp_out(disp_out), .cmos_out(cmos_out), .od_out(od_out),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .vec_zero(vec_zero), .status(status));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic set_hold(logic v);
    hold_in = v;
    tick(3);
  endtask

  task automatic pulse_cks(logic force_it);
    cks_force = force_it;
    req_ckstp = 1'b1;
    tick();
    req_ckstp = 1'b0;
  endtask

  task automatic pulse_wait(logic cpu_only);
    wait_cpu_only = cpu_only;
    req_wait = 1'b1;
    tick();
    req_wait = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    chk_eq("R1 status in reset", status, 0);
    chk_eq("R1 cpu clk in reset", cpu_clk_en, 0);
    chk_eq("R1 osc in reset", osc_en, 1);
    chk_eq("R1 pins in reset", {disp_out, cmos_out, od_out}, 0);
    rst = 1'b0;
    tick();
    chk_eq("R1 status after release", status, 1);
    chk_eq("R1 vec_zero pulse", vec_zero, 1);
    chk_eq("R1 cpu clk after release", cpu_clk_en, 1);
    tick();
    chk_eq("R1 vec_zero single cycle", vec_zero, 0);
  endtask

  task automatic t_run_pins();
    disp_in = 8'h3C; cmos_in = 4'h5; od_in = 4'hA;
    tick();
    chk_eq("R13 pins follow", {disp_out, cmos_out, od_out}, {8'h3C, 4'h5, 4'hA});
  endtask

  task automatic t_cks_level();
    set_hold(1'b1);
    pulse_cks(1'b0);
    chk_eq("R3 conditional blocked by HOLD high", status, 1);
    set_hold(1'b0);
    cks_wake_edge = 1'b0;
    pulse_cks(1'b0);
    chk_eq("R3 conditional enters on HOLD low", status, 2);
    chk_eq("R5 clocks off", {osc_en, cpu_clk_en}, 0);
    tick();
    chk_eq("R5 pins parked", {disp_out, cmos_out, od_out}, 0);
    pulse_wait(1'b0);
    chk_eq("R12 wait ignored in clock stop", status, 2);
    hold_in = 1'b1;
    tick(2);
    chk_eq("R2 no wake before third edge", status, 2);
    tick();
    chk_eq("R6 level wake", status, 3);
    chk_eq("R7 settle clocks", {osc_en, cpu_clk_en}, 2'b10);
    tick(SETTLE_CYC - 1);
    chk_eq("R7 still settling", status, 3);
    tick();
    chk_eq("R7 run after settle", status, 1);
  endtask

  task automatic t_cks_force_edge();
    cks_wake_edge = 1'b1;
    pulse_cks(1'b1);
    chk_eq("R4 forced entry with HOLD high", status, 2);
    tick(5);
    chk_eq("R6 edge mode ignores entry level", status, 2);
    set_hold(1'b0);
    chk_eq("R6 edge wake", status, 3);
    tick(SETTLE_CYC);
    chk_eq("R7 run after settle edge", status, 1);
  endtask

  task automatic t_wait_osc();
    disp_in = 8'h81; cmos_in = 4'hC; od_in = 4'h3;
    tick();
    pulse_wait(1'b0);
    chk_eq("R8 wait osc entered", status, 4);
    chk_eq("R9 clocks", {osc_en, cpu_clk_en}, 2'b10);
    disp_in = 8'hFF; cmos_in = 4'h0; od_in = 4'hF;
    tick();
    chk_eq("R9 display blank, others frozen", {disp_out, cmos_out, od_out}, {8'h00, 4'hC, 4'h3});
    pulse_cks(1'b1);
    chk_eq("R12 clock stop ignored in wait", status, 4);
    tick(6);
    chk_eq("R11 no wake without change", status, 4);
    set_hold(1'b1);
    chk_eq("R11 wake on change", status, 1);
    tick();
    chk_eq("R13 pins follow after wait", {disp_out, cmos_out, od_out}, {8'hFF, 4'h0, 4'hF});
  endtask

  task automatic t_wait_cpu();
    disp_in = 8'h5A; cmos_in = 4'h7; od_in = 4'h1;
    tick();
    cks_force = 1'b0;
    wait_cpu_only = 1'b1;
    req_wait = 1'b1; req_ckstp = 1'b1;
    tick();
    req_wait = 1'b0; req_ckstp = 1'b0;
    chk_eq("R8 wait taken when clock stop blocked", status, 5);
    chk_eq("R10 clocks", {osc_en, cpu_clk_en}, 2'b10);
    disp_in = 8'h00; cmos_in = 4'hE; od_in = 4'hE;
    tick(4);
    chk_eq("R10 all pins frozen", {disp_out, cmos_out, od_out}, {8'h5A, 4'h7, 4'h1});
    chk_eq("R11 HOLD high at entry no wake", status, 5);
    set_hold(1'b0);
    chk_eq("R11 cpu wait wakes on change", status, 1);
  endtask

  task automatic t_priority();
    cks_force = 1'b1;
    wait_cpu_only = 1'b0;
    req_wait = 1'b1; req_ckstp = 1'b1;
    tick();
    req_wait = 1'b0; req_ckstp = 1'b0;
    chk_eq("R8 clock stop wins", status, 2);
    cks_wake_edge = 1'b0;
    set_hold(1'b1);
    tick(SETTLE_CYC);
    chk_eq("R7 back to run", status, 1);
  endtask

  initial begin
    t_reset();
    t_run_pins();
    t_cks_level();
    t_cks_force_edge();
    t_wait_osc();
    t_wait_cpu();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule